// File: doc/BRIEF.md
# Supertask History Table

This block keeps one record per supertask of a speculative multithreaded front end. A supertask is a chain of compiler-formed tasks that the hardware stitches together at run time. Each record keeps the task the chain starts with, the task it currently ends on, how many tasks lie on its main path, and a saturating confidence value. The record can grow one task at a time. It falls back to its starting task when its confidence runs out.

Three operations act on the table, and all three can be issued in the same clock cycle. An allocate operation creates a one-task record. A task-commit operation offers a committing task as a new tail for a record. The caller also supplies the successor facts needed to decide whether the task may join: whether it is the most likely successor of the current end task, the target count of the task, and the target count of the current end task. A supertask-commit operation reports which end task was actually reached, and this moves the confidence up or down. A combinational lookup returns, for any record, its end task and task count, a flag that allows prediction, and a flag that marks a looping record.

Top module: `sht_table`

## Requirements
- R1: After reset every record is invalid. A lookup of an invalid record returns valid, predict and loop all low.
- R2: An allocate sets start and end to the given task, sets the count to 1 and the confidence to mid-scale (4 of 0..7). The record is valid on the next cycle.
- R3: An offered task joins a record only if three things hold: the likely flag is set, the count is below MAX_TASKS (3), and the offered target count is strictly less than the end task's target count. In every other case the record is unchanged and `app_accept` stays low.
- R4: A task that joins becomes the new end task and the count rises by one, on the next cycle. `app_accept` is high in the same cycle as the request.
- R5: A supertask commit whose reached task equals the recorded end task raises confidence by one, saturating at 7.
- R6: A supertask commit whose reached task differs lowers confidence by one, saturating at 0.
- R7: When a commit leaves confidence at 0, the end task becomes the start task and the count becomes 1.
- R8: `lk_predict` is high exactly when the record is valid and its confidence is strictly greater than `pred_thresh`.
- R9: `lk_loop` is high exactly when the record is valid, its start equals its end, and its count is above 1.
- R10: When a commit and an append hit the same record in one cycle, the commit is applied first. The append is then judged against, and applied to, the result of the commit.
- R11: Commits and appends aimed at an invalid record have no effect. An allocate wins over a commit or an append to the same record in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_id | input | 3 | Record to allocate |
| alloc_task | input | 6 | Task that starts the record |
| app_valid | input | 1 | Append request |
| app_id | input | 3 | Record to extend |
| app_task | input | 6 | Candidate task |
| app_likely | input | 1 | Candidate is the most likely successor of the end task |
| app_tgt_cnt | input | 4 | Target count of the candidate |
| end_tgt_cnt | input | 4 | Target count of the current end task |
| app_accept | output | 1 | Append taken this cycle |
| cmt_valid | input | 1 | Supertask commit |
| cmt_id | input | 3 | Record that committed |
| cmt_task | input | 6 | End task actually reached |
| pred_thresh | input | 3 | Confidence threshold for prediction |
| lk_id | input | 3 | Record to look up |
| lk_valid | output | 1 | Looked-up record is valid |
| lk_end | output | 6 | End task of the record |
| lk_count | output | 2 | Task count of the record |
| lk_predict | output | 1 | Prediction allowed |
| lk_loop | output | 1 | Record loops back to its start |

## Verification
The bench sweeps every combination of the likely flag and the two target counts, including the case where they are equal. A design that used a non-strict comparison would accept on equal counts. The bench keeps appending past the size limit; an off-by-one limit would let the count wrap. Confidence is walked to both saturation points, and a counter that wrapped would show up as a sudden swing in the threshold sweep. A same-cycle commit that collapses a record and an append to that record separate the two update orders: the wrong order ends on the start task with a count of 1. The same pattern run against a never-allocated record shows whether invalid records are written by mistake.

// File: rtl/sht_pkg.sv
package sht_pkg;
    parameter int TASK_W    = 6;
    parameter int TGT_W     = 4;
    parameter int CONF_W    = 3;
    parameter int MAX_TASKS = 3;

    localparam int CNT_W = $clog2(MAX_TASKS + 1);
    localparam logic [CONF_W-1:0] CONF_MAX = '1;
    localparam logic [CONF_W-1:0] CONF_MID = CONF_W'(1) << (CONF_W - 1);

    typedef struct packed {
        logic              valid;
        logic [TASK_W-1:0] start_t;
        logic [TASK_W-1:0] end_t;
        logic [CNT_W-1:0]  count;
        logic [CONF_W-1:0] conf;
    } sht_entry_t;
endpackage

// File: rtl/sht_entry_next.sv
module sht_entry_next
    import sht_pkg::*;
(
    input  sht_entry_t          cur,
    input  logic                alloc_hit,
    input  logic [TASK_W-1:0]   alloc_task,
    input  logic                cmt_hit,
    input  logic [TASK_W-1:0]   cmt_task,
    input  logic                app_hit,
    input  logic [TASK_W-1:0]   app_task,
    input  logic                app_likely,
    input  logic [TGT_W-1:0]    app_tgt,
    input  logic [TGT_W-1:0]    end_tgt,
    output sht_entry_t          nxt,
    output logic                app_ok
);
    sht_entry_t post;

    always_comb begin
        // commit stage first
        post = cur;
        if (cmt_hit && cur.valid) begin
            if (cmt_task == cur.end_t) begin
                if (cur.conf != CONF_MAX)
                    post.conf = cur.conf + CONF_W'(1);
            end else begin
                if (cur.conf != '0)
                    post.conf = cur.conf - CONF_W'(1);
                if (cur.conf <= CONF_W'(1)) begin
                    post.end_t = cur.start_t;
                    post.count = CNT_W'(1);
                end
            end
        end

        // append stage judged on the committed view
        app_ok = app_hit && post.valid && app_likely &&
                 (post.count < CNT_W'(MAX_TASKS)) && (app_tgt < end_tgt);

        nxt = post;
        if (app_ok) begin
            nxt.end_t = app_task;
            nxt.count = post.count + CNT_W'(1);
        end

        if (alloc_hit) begin
            nxt.valid   = 1'b1;
            nxt.start_t = alloc_task;
            nxt.end_t   = alloc_task;
            nxt.count   = CNT_W'(1);
            nxt.conf    = CONF_MID;
            app_ok      = 1'b0;
        end
    end
endmodule

// File: rtl/sht_lookup.sv
module sht_lookup
    import sht_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int ID_W = $clog2(NUM_ENTRIES)
) (
    input  sht_entry_t          tbl [NUM_ENTRIES],
    input  logic [ID_W-1:0]     rd_id,
    input  logic [CONF_W-1:0]   thresh,
    output logic                rd_valid,
    output logic [TASK_W-1:0]   rd_end,
    output logic [CNT_W-1:0]    rd_count,
    output logic                rd_predict,
    output logic                rd_loop
);
    sht_entry_t sel;

    always_comb begin
        sel        = tbl[rd_id];
        rd_valid   = sel.valid;
        rd_end     = sel.valid ? sel.end_t : '0;
        rd_count   = sel.valid ? sel.count : '0;
        rd_predict = sel.valid && (sel.conf > thresh);
        rd_loop    = sel.valid && (sel.start_t == sel.end_t) &&
                     (sel.count > CNT_W'(1));
    end
endmodule

// File: rtl/sht_table.sv
module sht_table
    import sht_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int ID_W = $clog2(NUM_ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic [ID_W-1:0]     alloc_id,
    input  logic [TASK_W-1:0]   alloc_task,
    input  logic                app_valid,
    input  logic [ID_W-1:0]     app_id,
    input  logic [TASK_W-1:0]   app_task,
    input  logic                app_likely,
    input  logic [TGT_W-1:0]    app_tgt_cnt,
    input  logic [TGT_W-1:0]    end_tgt_cnt,
    output logic                app_accept,
    input  logic                cmt_valid,
    input  logic [ID_W-1:0]     cmt_id,
    input  logic [TASK_W-1:0]   cmt_task,
    input  logic [CONF_W-1:0]   pred_thresh,
    input  logic [ID_W-1:0]     lk_id,
    output logic                lk_valid,
    output logic [TASK_W-1:0]   lk_end,
    output logic [CNT_W-1:0]    lk_count,
    output logic                lk_predict,
    output logic                lk_loop
);
    sht_entry_t tbl_q [NUM_ENTRIES];
    sht_entry_t tbl_d [NUM_ENTRIES];
    sht_entry_t nxt_w [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] ok_w;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        sht_entry_next u_next (
            .cur        (tbl_q[g]),
            .alloc_hit  (alloc_valid && (alloc_id == ID_W'(g))),
            .alloc_task (alloc_task),
            .cmt_hit    (cmt_valid && (cmt_id == ID_W'(g))),
            .cmt_task   (cmt_task),
            .app_hit    (app_valid && (app_id == ID_W'(g))),
            .app_task   (app_task),
            .app_likely (app_likely),
            .app_tgt    (app_tgt_cnt),
            .end_tgt    (end_tgt_cnt),
            .nxt        (nxt_w[g]),
            .app_ok     (ok_w[g])
        );
    end

    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) tbl_d[i] = nxt_w[i];
        app_accept = |ok_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) tbl_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    sht_lookup #(.NUM_ENTRIES(NUM_ENTRIES)) u_lookup (
        .tbl        (tbl_q),
        .rd_id      (lk_id),
        .thresh     (pred_thresh),
        .rd_valid   (lk_valid),
        .rd_end     (lk_end),
        .rd_count   (lk_count),
        .rd_predict (lk_predict),
        .rd_loop    (lk_loop)
    );

    // trackers for the checks below
    logic              trk_app_q, trk_alloc_q;
    logic [ID_W-1:0]   trk_app_id_q, trk_alloc_id_q;
    logic [TASK_W-1:0] trk_app_task_q, trk_alloc_task_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_app_q        <= 1'b0;
            trk_alloc_q      <= 1'b0;
            trk_app_id_q     <= '0;
            trk_alloc_id_q   <= '0;
            trk_app_task_q   <= '0;
            trk_alloc_task_q <= '0;
        end else begin
            trk_app_q        <= app_accept;
            trk_alloc_q      <= alloc_valid;
            trk_app_id_q     <= app_id;
            trk_alloc_id_q   <= alloc_id;
            trk_app_task_q   <= app_task;
            trk_alloc_task_q <= alloc_task;
        end
    end

    AST_ACCEPT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        app_accept |-> (app_valid && app_likely && (app_tgt_cnt < end_tgt_cnt))); // R3
    AST_APPEND_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        trk_app_q |-> (tbl_q[trk_app_id_q].end_t == trk_app_task_q &&
                       tbl_q[trk_app_id_q].count >= CNT_W'(2))); // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_count >= CNT_W'(1) && lk_count <= CNT_W'(MAX_TASKS))); // R4
    AST_ALLOC_MID: assert property (@(posedge clk) disable iff (!rst_n)
        trk_alloc_q |-> (tbl_q[trk_alloc_id_q].conf == CONF_MID &&
                         tbl_q[trk_alloc_id_q].end_t == trk_alloc_task_q)); // R2
    AST_ALLOC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && app_valid && alloc_id == app_id) |-> !app_accept); // R11
    AST_PRED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_predict || lk_loop) |-> lk_valid); // R8
endmodule

// File: tb/sht_table_tb_top.sv
`timescale 1ns/1ps
module sht_table_tb_top;
    import sht_pkg::*;
    localparam int N = 8;

    logic clk = 0, rst_n = 0;
    logic alloc_valid = 0, app_valid = 0, cmt_valid = 0, app_likely = 0;
    logic [2:0] alloc_id = 0, app_id = 0, cmt_id = 0, lk_id = 0, pred_thresh = 0;
    logic [5:0] alloc_task = 0, app_task = 0, cmt_task = 0;
    logic [3:0] app_tgt_cnt = 0, end_tgt_cnt = 0;
    logic app_accept, lk_valid, lk_predict, lk_loop;
    logic [5:0] lk_end;
    logic [1:0] lk_count;

    int total = 0, bad = 0;
    bit done = 0;

    // bench model
    bit m_valid [N];
    int m_start [N], m_end [N], m_cnt [N], m_conf [N];

    always #4 clk = ~clk;

    sht_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_id(alloc_id), .alloc_task(alloc_task),
        .app_valid(app_valid), .app_id(app_id), .app_task(app_task),
        .app_likely(app_likely), .app_tgt_cnt(app_tgt_cnt), .end_tgt_cnt(end_tgt_cnt),
        .app_accept(app_accept),
        .cmt_valid(cmt_valid), .cmt_id(cmt_id), .cmt_task(cmt_task),
        .pred_thresh(pred_thresh), .lk_id(lk_id),
        .lk_valid(lk_valid), .lk_end(lk_end), .lk_count(lk_count),
        .lk_predict(lk_predict), .lk_loop(lk_loop)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_entry(input int id, input string tag);
        bit ev;
        int ee, ec;
        ev = m_valid[id];
        ee = ev ? m_end[id] : 0;
        ec = ev ? m_cnt[id] : 0;
        lk_id = 3'(id);
        pred_thresh = 0;
        #1;
        chk(lk_valid == ev, {tag, " valid"}, lk_valid, ev);
        chk(lk_end == 6'(ee), {tag, " end"}, lk_end, ee);
        chk(lk_count == 2'(ec), {tag, " count"}, lk_count, ec);
        chk(lk_loop == (ev && m_start[id] == m_end[id] && m_cnt[id] > 1),
            "R9 loop", lk_loop, (ev && m_start[id] == m_end[id] && m_cnt[id] > 1));
        for (int t = 0; t < 8; t++) begin
            pred_thresh = 3'(t);
            #1;
            chk(lk_predict == (ev && m_conf[id] > t), "R8 predict",
                lk_predict, (ev && m_conf[id] > t));
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < N; i++) check_entry(i, tag);
    endtask

    task automatic model_commit(input int id, input int t);
        if (t == m_end[id]) begin
            if (m_conf[id] < 7) m_conf[id]++;
        end else begin
            if (m_conf[id] > 0) m_conf[id]--;
            if (m_conf[id] == 0) begin
                m_end[id] = m_start[id];
                m_cnt[id] = 1;
            end
        end
    endtask

    task automatic do_cycle(
        input bit av, input int aid, input int atask,
        input bit pv, input int pid, input int ptask, input bit lik, input int at, input int et,
        input bit cv, input int cid, input int ctask);
        bit exp_acc;
        bit sv;
        int sc, se;
        @(negedge clk);
        alloc_valid = av; alloc_id = 3'(aid); alloc_task = 6'(atask);
        app_valid = pv; app_id = 3'(pid); app_task = 6'(ptask);
        app_likely = lik; app_tgt_cnt = 4'(at); end_tgt_cnt = 4'(et);
        cmt_valid = cv; cmt_id = 3'(cid); cmt_task = 6'(ctask);
        // commit first on the target record (R10)
        sv = m_valid[pid]; sc = m_cnt[pid]; se = m_end[pid];
        if (cv && cid == pid && m_valid[pid]) begin
            if (ctask != se && m_conf[pid] <= 1) sc = 1;
        end
        exp_acc = pv && !(av && aid == pid) && sv && lik && sc < 3 && at < et;
        #1;
        chk(app_accept == exp_acc, "R3 accept", app_accept, exp_acc);
        @(posedge clk);
        if (cv && m_valid[cid] && !(av && aid == cid)) model_commit(cid, ctask);
        if (exp_acc) begin
            m_end[pid] = ptask;
            m_cnt[pid]++;
        end
        if (av) begin
            m_valid[aid] = 1; m_start[aid] = atask; m_end[aid] = atask;
            m_cnt[aid] = 1; m_conf[aid] = 4;
        end
        #1;
        alloc_valid = 0; app_valid = 0; cmt_valid = 0;
    endtask

    task automatic alloc(input int id, input int t);
        do_cycle(1, id, t, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic append(input int id, input int t, input bit lik, input int at, input int et);
        do_cycle(0, 0, 0, 1, id, t, lik, at, et, 0, 0, 0);
    endtask
    task automatic commit(input int id, input int t);
        do_cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, id, t);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned x;
        int unsigned r1, r2;
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_start[i] = 0; m_end[i] = 0; m_cnt[i] = 0; m_conf[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check_all("R1");

        // R2 allocate
        alloc(0, 5);
        check_entry(0, "R2");

        // R3 sweep of the three gating conditions
        for (int lik = 0; lik < 2; lik++)
            for (int at = 0; at < 4; at++)
                for (int et = 0; et < 4; et++) begin
                    alloc(0, 5);
                    append(0, 10 + at, lik[0], at, et);
                    check_entry(0, "R3");
                end

        // R4 growth up to the size limit, then refusal
        alloc(3, 2);
        for (int k = 0; k < 4; k++) begin
            append(3, 20 + k, 1, 1, 3);
            check_entry(3, "R4");
        end

        // R5 saturate up, R6/R7 walk down to zero and collapse
        for (int k = 0; k < 5; k++) begin
            commit(3, m_end[3]);
            check_entry(3, "R5");
        end
        for (int k = 0; k < 9; k++) begin
            commit(3, 63);
            check_entry(3, "R6");
        end
        check_entry(3, "R7");

        // R9 loop record
        alloc(1, 9);
        append(1, 9, 1, 0, 2);
        check_entry(1, "R9");

        // R10 commit collapses, append applies on top
        alloc(2, 1);
        append(2, 2, 1, 0, 1);
        append(2, 4, 1, 0, 1);
        for (int k = 0; k < 3; k++) commit(2, 60);
        check_entry(2, "R10");
        do_cycle(0, 0, 0, 1, 2, 3, 1, 0, 1, 1, 2, 61);
        check_entry(2, "R10");

        // R11 invalid record untouched, alloc wins over append
        append(7, 6, 1, 0, 3);
        commit(7, 6);
        check_entry(7, "R11");
        do_cycle(1, 4, 8, 1, 4, 9, 1, 0, 3, 1, 4, 8);
        check_entry(4, "R11");

        // mixed pseudo-random traffic
        x = 32'h1234_5678;
        for (int c = 0; c < 600; c++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5; r1 = x;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5; r2 = x;
            do_cycle(r1[2:0] == 0, int'(r1[5:3]), int'(r1[8:6]),
                     r1[9] | r1[10], int'(r1[13:11]), int'(r1[16:14]), r1[17] | r1[18],
                     int'(r1[20:19]), int'(r1[22:21]),
                     r2[0] | r2[1], int'(r2[4:2]), int'(r2[7:5]));
            check_all("R11 mix");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule